// File: doc/BRIEF.md
# Frame Timing Generator

This block produces the raster timing for a display pipeline: horizontal and vertical sync pulses, a data-enable strobe, and the current pixel column and row inside the visible area. Every segment length it is given, whether sync width, back porch, visible size or front porch, is held as its true count minus one. The pixel rate comes from an internal divider whose field also holds the ratio minus one. A field value of zero passes the system clock through at full rate. The all-ones field value is clamped to a ratio of 255.

A frame interrupt can be placed at the start of any of the four vertical segments. The normal choice is the vsync segment. The pending bit is cleared by a write of one. A second output flags the visible line whose index matches a programmed threshold. Scanning starts only while the enable bit and its frame-latched companion are both set. When they are not, the counters rest at the first pixel of the frame.

Top module: `frame_timing_gen`

## Requirements
- R1: After reset, hsync_o, vsync_o, de_o, line_hit_o, irq_pend_o and irq_o are low, and x_o and y_o are zero.
- R2: While video_en_i and video_en_f_i are not both high, hsync_o, vsync_o, de_o and line_hit_o are low and x_o and y_o are zero. The next time both go high, scanning restarts at the first sync pixel of the first sync line.
- R3: With div_m1_i equal to d and d below 255, the pixel position advances once every d+1 clock cycles. With d = 0 it advances on every cycle.
- R4: A div_m1_i value of 255 gives a ratio of 255 clock cycles per pixel, not 256.
- R5: Each line runs through four segments in this order: hsync for hsync_m1_i+1 pixels, back porch for hbp_m1_i+1, visible for hact_m1_i+1, then front porch for hfp_m1_i+1. hsync_o is high exactly during the first segment.
- R6: Each frame runs through the same four segments, counted in lines: vsync_m1_i+1, vbp_m1_i+1, vact_m1_i+1, vfp_m1_i+1. vsync_o is high exactly during the vsync lines.
- R7: de_o is high only when both the horizontal and vertical positions are in their visible segments. x_o gives the pixel offset inside the visible horizontal segment and is 0 elsewhere. y_o gives the line offset inside the visible vertical segment and is 0 elsewhere.
- R8: line_hit_o is high for the whole visible line whose offset equals line_thr_i. The usual setting of line_thr_i is vact_m1_i, which marks the last visible line.
- R9: irq_pend_o is set on the clock edge at which scanning enters line 0, pixel 0 of the vertical segment chosen by frame_sel_i. The encoding is 0 = vsync, 1 = back porch, 2 = visible, 3 = front porch. It is set only while frame_irq_en_i is high.
- R10: A cycle with clr_wr_i high and clr_data_i high clears irq_pend_o on the next edge. clr_data_i = 0 has no effect. A set in the same cycle wins over the clear.
- R11: irq_o is high exactly when irq_pend_o, irq_en_i and frame_irq_en_i are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| video_en_i | input | 1 | Video enable |
| video_en_f_i | input | 1 | Frame-latched video enable companion |
| div_m1_i | input | 8 | Pixel clock ratio minus one |
| hsync_m1_i | input | 12 | Hsync width minus one (pixels) |
| hbp_m1_i | input | 12 | Horizontal back porch minus one |
| hact_m1_i | input | 12 | Visible pixels per line minus one |
| hfp_m1_i | input | 12 | Horizontal front porch minus one |
| vsync_m1_i | input | 12 | Vsync width minus one (lines) |
| vbp_m1_i | input | 12 | Vertical back porch minus one |
| vact_m1_i | input | 12 | Visible lines minus one |
| vfp_m1_i | input | 12 | Vertical front porch minus one |
| line_thr_i | input | 12 | Visible line offset flagged by line_hit_o |
| irq_en_i | input | 1 | Global interrupt enable |
| frame_irq_en_i | input | 1 | Frame interrupt enable |
| frame_sel_i | input | 2 | Vertical segment that raises the frame event |
| clr_wr_i | input | 1 | Write strobe to the pending bit |
| clr_data_i | input | 1 | Write data; 1 clears the pending bit |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable |
| x_o | output | 12 | Visible column offset |
| y_o | output | 12 | Visible row offset |
| line_hit_o | output | 1 | Threshold line reached |
| irq_pend_o | output | 1 | Frame event pending |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The assertions assume that the timing, divider and threshold inputs change only while scanning is stopped. The counters compare against these inputs on every cycle, so a value changed in mid-frame would break the segment order that the properties rely on. The stimulus picks a new random geometry, ratio, threshold and interrupt setup only while both enables are low. During scanning it changes nothing except the clear strobe and its data, which it drives at random. Directed cases cover the smallest segments with full-rate clocking and the clamped maximum divider.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  localparam int NSEG = 4;

  function automatic seg_e seg_next(seg_e s);
    case (s)
      SEG_SYNC: return SEG_BACK;
      SEG_BACK: return SEG_ACT;
      SEG_ACT:  return SEG_FRONT;
      default:  return SEG_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/ftg_pixdiv.sv
module ftg_pixdiv #(
  parameter int DIVW     = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [DIVW-1:0] ratio_m1_i,
  output logic            tick_o
);
  localparam logic [DIVW-1:0] FIELD_MAX = {DIVW{1'b1}};
  localparam logic [DIVW-1:0] LIM_MAX   = {{(DIVW-1){1'b1}}, 1'b0};

  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] lim;

  generate
    if (SATURATE) begin : g_sat
      // all-ones field clamps to one below the field range
      assign lim = (ratio_m1_i == FIELD_MAX) ? LIM_MAX : ratio_m1_i;
    end else begin : g_raw
      assign lim = ratio_m1_i;
    end
  endgenerate

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ftg_axis.sv
module ftg_axis
  import ftg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  input  logic [NSEG-1:0][W-1:0] len_m1_i,
  output seg_e                seg_o,
  output logic [W-1:0]        cnt_o,
  output logic                enter_o,
  output seg_e                nxt_o
);
  seg_e         seg_q;
  logic [W-1:0] cnt_q;
  logic         at_lim;

  assign at_lim  = (cnt_q == len_m1_i[seg_q]);
  assign nxt_o   = seg_next(seg_q);
  assign enter_o = run_i && step_i && at_lim;
  assign seg_o   = seg_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (!run_i) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (step_i) begin
      if (at_lim) begin
        seg_q <= nxt_o;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ftg_irq.sv
module ftg_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic frame_en_i,
  input  logic irq_en_i,
  input  logic clr_wr_i,
  input  logic clr_data_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pend_q <= 1'b0;
    else if (event_i && frame_en_i)     pend_q <= 1'b1;  // set wins
    else if (clr_wr_i && clr_data_i)    pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && irq_en_i && frame_en_i;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import ftg_pkg::*;
#(
  parameter int HW   = 12,
  parameter int VW   = 12,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            video_en_i,
  input  logic            video_en_f_i,
  input  logic [DIVW-1:0] div_m1_i,
  input  logic [HW-1:0]   hsync_m1_i,
  input  logic [HW-1:0]   hbp_m1_i,
  input  logic [HW-1:0]   hact_m1_i,
  input  logic [HW-1:0]   hfp_m1_i,
  input  logic [VW-1:0]   vsync_m1_i,
  input  logic [VW-1:0]   vbp_m1_i,
  input  logic [VW-1:0]   vact_m1_i,
  input  logic [VW-1:0]   vfp_m1_i,
  input  logic [VW-1:0]   line_thr_i,
  input  logic            irq_en_i,
  input  logic            frame_irq_en_i,
  input  logic [1:0]      frame_sel_i,
  input  logic            clr_wr_i,
  input  logic            clr_data_i,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            de_o,
  output logic [HW-1:0]   x_o,
  output logic [VW-1:0]   y_o,
  output logic            line_hit_o,
  output logic            irq_pend_o,
  output logic            irq_o
);
  logic run, tick;
  logic h_enter, v_enter, h_wrap, frame_ev;
  seg_e h_seg, v_seg, h_nxt, v_nxt, sel;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic [NSEG-1:0][HW-1:0] h_len;
  logic [NSEG-1:0][VW-1:0] v_len;

  assign run = video_en_i && video_en_f_i;
  assign sel = seg_e'(frame_sel_i);

  // segment order is the index order of the length arrays
  assign h_len = {hfp_m1_i, hact_m1_i, hbp_m1_i, hsync_m1_i};
  assign v_len = {vfp_m1_i, vact_m1_i, vbp_m1_i, vsync_m1_i};

  ftg_pixdiv #(.DIVW(DIVW), .SATURATE(1'b1)) i_div (
    .clk_i, .rst_ni, .run_i(run), .ratio_m1_i(div_m1_i), .tick_o(tick)
  );

  ftg_axis #(.W(HW)) i_h (
    .clk_i, .rst_ni, .run_i(run), .step_i(tick), .len_m1_i(h_len),
    .seg_o(h_seg), .cnt_o(h_cnt), .enter_o(h_enter), .nxt_o(h_nxt)
  );

  assign h_wrap = h_enter && (h_nxt == SEG_SYNC);

  ftg_axis #(.W(VW)) i_v (
    .clk_i, .rst_ni, .run_i(run), .step_i(h_wrap), .len_m1_i(v_len),
    .seg_o(v_seg), .cnt_o(v_cnt), .enter_o(v_enter), .nxt_o(v_nxt)
  );

  assign frame_ev = v_enter && (v_nxt == sel);

  ftg_irq i_irq (
    .clk_i, .rst_ni, .event_i(frame_ev), .frame_en_i(frame_irq_en_i),
    .irq_en_i, .clr_wr_i, .clr_data_i, .pend_o(irq_pend_o), .irq_o
  );

  logic h_act, v_act;
  assign h_act      = run && (h_seg == SEG_ACT);
  assign v_act      = run && (v_seg == SEG_ACT);
  assign hsync_o    = run && (h_seg == SEG_SYNC);
  assign vsync_o    = run && (v_seg == SEG_SYNC);
  assign de_o       = h_act && v_act;
  assign x_o        = h_act ? h_cnt : '0;
  assign y_o        = v_act ? v_cnt : '0;
  assign line_hit_o = v_act && (v_cnt == line_thr_i);
endmodule

// File: rtl/ftg_checker.sv
module ftg_checker #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          video_en_i,
  input logic          video_en_f_i,
  input logic [HW-1:0] hact_m1_i,
  input logic [VW-1:0] vact_m1_i,
  input logic [VW-1:0] line_thr_i,
  input logic          frame_irq_en_i,
  input logic          clr_wr_i,
  input logic          clr_data_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [HW-1:0] x_o,
  input logic [VW-1:0] y_o,
  input logic          line_hit_o,
  input logic          irq_pend_o,
  input logic          irq_o
);
  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(video_en_i && video_en_f_i) |-> !hsync_o && !vsync_o && !de_o && !line_hit_o);

  assert_de_no_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !hsync_o && !vsync_o);

  assert_pos_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (x_o <= hact_m1_i) && (y_o <= vact_m1_i));

  assert_hit_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_hit_o && de_o) |-> (y_o == line_thr_i));

  assert_no_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_pend_o && !frame_irq_en_i) |=> !irq_pend_o);

  assert_pend_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o && !(clr_wr_i && clr_data_i)) |=> irq_pend_o);

  assert_irq_pend_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_pend_o);
endmodule

bind frame_timing_gen ftg_checker #(.HW(HW), .VW(VW)) i_ftg_checker (.*);

// File: tb/test_frame_timing_gen.sv
module test_frame_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic video_en_i = 0, video_en_f_i = 0;
  logic [7:0] div_m1_i = '0;
  logic [11:0] hsync_m1_i = '0, hbp_m1_i = '0, hact_m1_i = '0, hfp_m1_i = '0;
  logic [11:0] vsync_m1_i = '0, vbp_m1_i = '0, vact_m1_i = '0, vfp_m1_i = '0;
  logic [11:0] line_thr_i = '0;
  logic irq_en_i = 0, frame_irq_en_i = 0, clr_wr_i = 0, clr_data_i = 0;
  logic [1:0] frame_sel_i = '0;
  logic hsync_o, vsync_o, de_o, line_hit_o, irq_pend_o, irq_o;
  logic [11:0] x_o, y_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  frame_timing_gen i_frame_timing_gen (.*);

  int checks = 0, errs = 0;
  int hs, hb, ha, hf, vs, vb, va, vf, nrat, thr, sel;
  int k = 0;
  bit exp_pend = 0, last_clr = 0, sat_cfg = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at k=%0d", tag, act, exp, k);
    end
  endtask

  function automatic int seg_of(int pos, int s, int b, int a);
    if (pos < s) return 0;
    if (pos < s + b) return 1;
    if (pos < s + b + a) return 2;
    return 3;
  endfunction

  function automatic int off_of(int pos, int s, int b, int a);
    case (seg_of(pos, s, b, a))
      0: return pos;
      1: return pos - s;
      2: return pos - s - b;
      default: return pos - s - b - a;
    endcase
  endfunction

  function automatic bit run_now();
    return video_en_i && video_en_f_i;
  endfunction

  // model of the edge just taken, from the requirements
  task automatic model_update();
    bit ev = 0;
    last_clr = 0;
    if (!run_now()) k = 0;
    else begin
      int p, h, l, ht, vt;
      k++;
      ht = hs + hb + ha + hf;
      vt = vs + vb + va + vf;
      if (k % nrat == 0) begin
        p = k / nrat; h = p % ht; l = (p / ht) % vt;
        if (h == 0 && off_of(l, vs, vb, va) == 0 && seg_of(l, vs, vb, va) == sel) ev = 1;
      end
    end
    if (ev && frame_irq_en_i) exp_pend = 1;
    else if (clr_wr_i && clr_data_i) begin exp_pend = 0; last_clr = 1; end
  endtask

  task automatic compare();
    if (run_now()) begin
      int p, h, l, hsg, vsg, hof, vof;
      p = k / nrat;
      h = p % (hs + hb + ha + hf);
      l = (p / (hs + hb + ha + hf)) % (vs + vb + va + vf);
      hsg = seg_of(h, hs, hb, ha); hof = off_of(h, hs, hb, ha);
      vsg = seg_of(l, vs, vb, va); vof = off_of(l, vs, vb, va);
      chk("R5", hsync_o, hsg == 0);
      chk(sat_cfg ? "R4" : "R3", x_o, (hsg == 2) ? hof : 0);
      chk("R6", vsync_o, vsg == 0);
      chk("R7", de_o, (hsg == 2) && (vsg == 2));
      chk("R7", x_o, (hsg == 2) ? hof : 0);
      chk("R7", y_o, (vsg == 2) ? vof : 0);
      chk("R8", line_hit_o, (vsg == 2) && (vof == thr));
    end else begin
      chk("R2", hsync_o, 0); chk("R2", vsync_o, 0); chk("R2", de_o, 0);
      chk("R2", line_hit_o, 0); chk("R2", x_o, 0); chk("R2", y_o, 0);
    end
    chk(last_clr ? "R10" : "R9", irq_pend_o, exp_pend);
    chk("R11", irq_o, exp_pend && irq_en_i && frame_irq_en_i);
  endtask

  task automatic cycle();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare();
  endtask

  task automatic set_cfg(int a_hs, int a_hb, int a_ha, int a_hf, int a_vs, int a_vb,
                         int a_va, int a_vf, int field, int a_thr, int a_sel,
                         bit ien, bit fen);
    hs = a_hs; hb = a_hb; ha = a_ha; hf = a_hf;
    vs = a_vs; vb = a_vb; va = a_va; vf = a_vf;
    thr = a_thr; sel = a_sel;
    nrat = (field == 255) ? 255 : field + 1;
    sat_cfg = (field == 255);
    hsync_m1_i = 12'(hs - 1); hbp_m1_i = 12'(hb - 1); hact_m1_i = 12'(ha - 1); hfp_m1_i = 12'(hf - 1);
    vsync_m1_i = 12'(vs - 1); vbp_m1_i = 12'(vb - 1); vact_m1_i = 12'(va - 1); vfp_m1_i = 12'(vf - 1);
    div_m1_i = 8'(field); line_thr_i = 12'(thr); frame_sel_i = 2'(sel);
    irq_en_i = ien; frame_irq_en_i = fen;
  endtask

  task automatic run_cfg(int ncyc);
    // half enables only: must stay idle (R2)
    video_en_i = 1; video_en_f_i = 0;
    repeat (3) cycle();
    video_en_i = 0; video_en_f_i = 1;
    repeat (3) cycle();
    video_en_i = 1;
    for (int i = 0; i < ncyc; i++) begin
      if ($urandom_range(0, 39) == 0) begin
        clr_wr_i = 1; clr_data_i = 1'($urandom_range(0, 1));
      end else begin
        clr_wr_i = 0; clr_data_i = 0;
      end
      cycle();
    end
    clr_wr_i = 0; clr_data_i = 0;
    video_en_i = 0; video_en_f_i = 0;
    repeat (2) cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    chk("R1", hsync_o, 0); chk("R1", vsync_o, 0); chk("R1", de_o, 0);
    chk("R1", irq_pend_o, 0); chk("R1", irq_o, 0); chk("R1", x_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", line_hit_o, 0); chk("R1", y_o, 0); chk("R1", irq_pend_o, 0);

    // directed: minimum segments, full-rate pixel clock, vsync event
    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 1);
    run_cfg(2 * 16 + 3);
    // directed: clamped maximum divider, last visible line threshold
    set_cfg(1, 1, 2, 1, 1, 1, 2, 1, 255, 1, 2, 1, 1);
    run_cfg(255 * 5 * 5 + 40);
    // directed: ratio 2, front-porch event with frame enable off
    set_cfg(2, 1, 3, 2, 1, 2, 3, 1, 1, 2, 3, 1, 0);
    run_cfg(2 * 2 * 8 * 7 + 5);

    for (int c = 0; c < 10; c++) begin
      int r_hs, r_hb, r_ha, r_hf, r_vs, r_vb, r_va, r_vf, fld;
      r_hs = $urandom_range(1, 4); r_hb = $urandom_range(1, 4);
      r_ha = $urandom_range(1, 8); r_hf = $urandom_range(1, 4);
      r_vs = $urandom_range(1, 3); r_vb = $urandom_range(1, 3);
      r_va = $urandom_range(1, 6); r_vf = $urandom_range(1, 3);
      fld = $urandom_range(0, 3);
      set_cfg(r_hs, r_hb, r_ha, r_hf, r_vs, r_vb, r_va, r_vf, fld,
              $urandom_range(0, r_va), $urandom_range(0, 3),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
      run_cfg(2 * (fld + 1) * (r_hs + r_hb + r_ha + r_hf) * (r_vs + r_vb + r_va + r_vf) + 7);
    end

    // clear with data 0 ignored, data 1 clears (R10)
    set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 1);
    video_en_i = 1; video_en_f_i = 1;
    repeat (17) cycle();
    video_en_i = 0; video_en_f_i = 0;
    cycle();
    chk("R10", irq_pend_o, 1);
    clr_wr_i = 1; clr_data_i = 0;
    cycle();
    chk("R10", irq_pend_o, 1);
    clr_data_i = 1;
    cycle();
    chk("R10", irq_pend_o, 0);
    clr_wr_i = 0; clr_data_i = 0;
    cycle();

    summary();
    $finish;
  end
endmodule